// File: doc/BRIEF.md
# Boost Switch Gate Sequencer with Forced Off-Time

This block drives the power switch of a boost-stage power-factor controller that regulates the averaged inductor current. A pulse on `cycle_start` begins each switching period. The gate is forced low for a fixed number of clock ticks, and `ramp_hold` keeps the external ramp discharged during that window. After the window, the ramp runs freely. The gate is switched on once an external analog comparator reports, through `ramp_cross`, that the ramp has reached the averaged-current level.

A cycle-by-cycle current limit sits beside the on-latch. A raw over-current flag has to stay high for a programmable number of consecutive clocks before it counts. When it does, the limit latch keeps the gate low for the rest of the period. The forced off-time window clears both latches and takes priority over every other latch input. A global disable input removes the gate combinationally, for example during supply undervoltage or any other fault, and leaves the latch state unchanged.

Top module: `boost_gate_sequencer`

## Requirements
- R1: While reset is applied, and right after it is released, `gate_out` and `ramp_hold` are both 0.
- R2: A `cycle_start` sampled high while no off-time is running makes `ramp_hold` high for exactly OFF_TICKS consecutive cycles, starting the cycle after the sampling edge. `gate_out` is 0 whenever `ramp_hold` is 1.
- R3: A `cycle_start` sampled high while the off-time is running is ignored, and the window length stays OFF_TICKS.
- R4: After the window ends, `gate_out` rises one clock after the first edge at which `ramp_cross` is sampled high. If `ramp_cross` is already high when the window ends, `gate_out` rises in the very next cycle. A high `ramp_cross` during the window never turns the gate on.
- R5: Once on, `gate_out` stays high after `ramp_cross` falls, until the next accepted `cycle_start` starts a window. `gate_out` drops in the same cycle that `ramp_hold` rises.
- R6: If `oc_raw` is sampled high at DGL_TICKS consecutive edges, `gate_out` is 0 from the cycle after the next edge onward. A shorter run of high samples has no effect.
- R7: After a current-limit trip, `gate_out` stays 0 for the rest of the period, even if `ramp_cross` rises later.
- R8: The off-time window clears both the on-latch and the limit latch with top priority. A trip left over from the previous period does not block the next period. An over-current run that both starts and ends inside the window has no effect.
- R9: `fault_off` high forces `gate_out` to 0 in the same cycle. When `fault_off` is released, the gate returns to the state held by the latches.
- R10: With the default OFF_TICKS of 40 at a 50 MHz clock and a 769-clock period (65 kHz), the gate is high for at most 95 % of the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cycle_start | input | 1 | Strobe that starts a switching period |
| ramp_cross | input | 1 | Comparator flag: ramp has reached the averaged-current level |
| oc_raw | input | 1 | Undeglitched over-current flag |
| fault_off | input | 1 | Global disable; forces the gate low combinationally |
| gate_out | output | 1 | Boost switch gate drive, active high |
| ramp_hold | output | 1 | High while the ramp must be held discharged |

## Verification
Several periods are run in sequence. In each one the comparator crossing, the over-current run and a second strobe are placed at a different point of the period. The crossings come before, at and well after the window edge, and one is a single-cycle pulse; these separate release timing from latch holding. Over-current runs one tick short of and exactly at the deglitch length test the filter threshold. Runs placed before the crossing, across the window edge and wholly inside the window show that the limit latch keeps its grip and that the window clears it. A full-length 65 kHz period bounds the duty cycle, and toggling the disable while the gate is on shows the masking is combinational and leaves the latch state intact.

// File: rtl/bgs_pkg.sv
package bgs_pkg;

    // Latch state of one switching period
    typedef struct packed {
        logic pwm_on;   // set by the ramp crossing
        logic ilim;     // set by the deglitched over-current flag
    } latch_t;

endpackage

// File: rtl/bgs_offtime_timer.sv
module bgs_offtime_timer #(
    parameter int OFF_TICKS = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic active
);
    localparam int CW = $clog2(OFF_TICKS + 1);
    localparam logic [CW-1:0] LOAD = CW'(OFF_TICKS);
    localparam logic [CW-1:0] ONE  = CW'(1);

    logic [CW-1:0] cnt_d, cnt_q;

    // A running window counts down; a start strobe is honoured only when idle
    always_comb begin
        cnt_d = cnt_q;
        if (cnt_q != '0) begin
            cnt_d = cnt_q - ONE;
        end else if (start) begin
            cnt_d = LOAD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign active = (cnt_q != '0);

endmodule

// File: rtl/bgs_oc_filter.sv
module bgs_oc_filter #(
    parameter int DGL_TICKS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic trip
);
    localparam int CW = $clog2(DGL_TICKS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(DGL_TICKS);
    localparam logic [CW-1:0] ONE   = CW'(1);

    logic [CW-1:0] run_d, run_q;

    // Saturating run-length counter of consecutive high samples
    always_comb begin
        run_d = run_q;
        if (!raw) begin
            run_d = '0;
        end else if (run_q != LIMIT) begin
            run_d = run_q + ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else begin
            run_q <= run_d;
        end
    end

    assign trip = (run_q == LIMIT);

endmodule

// File: rtl/boost_gate_sequencer.sv
module boost_gate_sequencer
    import bgs_pkg::*;
#(
    parameter int OFF_TICKS = 40,
    parameter int DGL_TICKS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cycle_start,
    input  logic ramp_cross,
    input  logic oc_raw,
    input  logic fault_off,
    output logic gate_out,
    output logic ramp_hold
);
    logic   offtime;
    logic   oc_trip;
    latch_t st_d, st_q;

    bgs_offtime_timer #(
        .OFF_TICKS (OFF_TICKS)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (cycle_start),
        .active (offtime)
    );

    bgs_oc_filter #(
        .DGL_TICKS (DGL_TICKS)
    ) u_filter (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (oc_raw),
        .trip  (oc_trip)
    );

    // The off-time window outranks every other latch input
    always_comb begin
        st_d = st_q;
        if (offtime) begin
            st_d.pwm_on = 1'b0;
            st_d.ilim   = 1'b0;
        end else begin
            if (oc_trip) begin
                st_d.ilim = 1'b1;
            end
            if (st_d.ilim) begin
                st_d.pwm_on = 1'b0;
            end else if (ramp_cross) begin
                st_d.pwm_on = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Masking after the latches: window and disable act in the same cycle
    assign gate_out  = st_q.pwm_on & ~st_q.ilim & ~offtime & ~fault_off;
    assign ramp_hold = offtime;

endmodule

// File: rtl/bgs_checker.sv
module bgs_checker #(
    parameter int OFF_TICKS = 40
) (
    input logic clk,
    input logic rst_n,
    input logic ramp_hold,
    input logic gate_out,
    input logic ramp_cross,
    input logic fault_off,
    input logic oc_trip
);
    localparam int LW = $clog2(OFF_TICKS + 2);
    localparam logic [LW-1:0] LCAP = LW'(OFF_TICKS + 1);
    localparam logic [LW-1:0] LNOM = LW'(OFF_TICKS);

    logic [LW-1:0] len_q;

    // Length of the current high run of ramp_hold
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q <= '0;
        end else if (!ramp_hold) begin
            len_q <= '0;
        end else if (len_q != LCAP) begin
            len_q <= len_q + LW'(1);
        end
    end

    assert_hold_masks_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ramp_hold |-> !gate_out);

    assert_window_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ramp_hold) |-> (len_q == LNOM));

    assert_rise_after_cross_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(gate_out) && !$past(fault_off)) |-> $past(ramp_cross));

    assert_trip_kills_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        oc_trip |=> !gate_out);

    assert_disable_masks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fault_off |-> !gate_out);

endmodule

bind boost_gate_sequencer bgs_checker #(
    .OFF_TICKS (OFF_TICKS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ramp_hold  (ramp_hold),
    .gate_out   (gate_out),
    .ramp_cross (ramp_cross),
    .fault_off  (fault_off),
    .oc_trip    (oc_trip)
);

// File: tb/boost_gate_sequencer_tb.sv
`timescale 1ns/1ps
module boost_gate_sequencer_tb;
    localparam int OFF  = 40;
    localparam int DGL  = 10;
    localparam int PER  = 100;
    localparam int P65K = 769;

    // c/w: crossing start and width; s/l: over-current start and length;
    // x: index of an extra strobe (0 = none); g: expected gate-high count
    typedef struct packed {
        int c; int w; int s; int l; int x; int g; int tag;
    } row_t;

    localparam row_t ROWS [0:8] = '{
        '{0,  100, 0,  0,  0,  58, 4},  // R4 crossing already high at release
        '{50, 50,  0,  0,  20, 49, 4},  // R4 late crossing, R3 extra strobe
        '{45, 1,   0,  0,  0,  54, 5},  // R5 one-cycle crossing pulse holds
        '{42, 58,  60, 10, 0,  28, 6},  // R6 run exactly at deglitch length
        '{42, 58,  60, 9,  0,  57, 6},  // R6 run one tick short
        '{80, 20,  50, 12, 0,  0,  7},  // R7 trip before crossing
        '{41, 59,  0,  0,  0,  58, 8},  // R8 previous trip cleared
        '{45, 55,  1,  15, 0,  54, 8},  // R8 run inside window only
        '{0,  100, 30, 20, 0,  0,  7}   // R7 run spanning window end
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cycle_start = 1'b0;
    logic ramp_cross = 1'b0;
    logic oc_raw = 1'b0;
    logic fault_off = 1'b0;
    logic gate_out, ramp_hold;

    int checks = 0;
    int errors = 0;
    int overlap = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    boost_gate_sequencer #(
        .OFF_TICKS (OFF),
        .DGL_TICKS (DGL)
    ) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cycle_start (cycle_start),
        .ramp_cross  (ramp_cross),
        .oc_raw      (oc_raw),
        .fault_off   (fault_off),
        .gate_out    (gate_out),
        .ramp_hold   (ramp_hold)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One period of p clocks; counts are taken over negedges 1..p-1
    task automatic run_cycle(input int p, input int c, input int w, input int s,
                             input int l, input int x,
                             output int hold_n, output int gate_n);
        hold_n = 0;
        gate_n = 0;
        for (int k = 0; k < p; k++) begin
            cycle_start = (k == 0) || (x != 0 && k == x);
            ramp_cross  = (k >= c) && (k < c + w);
            oc_raw      = (l != 0) && (k >= s) && (k < s + l);
            #1;
            if (k > 0) begin
                if (ramp_hold) hold_n++;
                if (gate_out) gate_n++;
                if (ramp_hold && gate_out) overlap++;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        int hn, gn;
        repeat (3) @(negedge clk);
        #1;
        check(gate_out == 1'b0, "R1 gate in reset", int'(gate_out), 0);
        check(ramp_hold == 1'b0, "R1 hold in reset", int'(ramp_hold), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(gate_out == 1'b0 && ramp_hold == 1'b0, "R1 after release",
              int'({gate_out, ramp_hold}), 0);
        @(negedge clk);

        for (int i = 0; i < 9; i++) begin
            run_cycle(PER, ROWS[i].c, ROWS[i].w, ROWS[i].s, ROWS[i].l, ROWS[i].x, hn, gn);
            check(hn == OFF, (ROWS[i].x != 0) ? "R3 window length" : "R2 window length",
                  hn, OFF);
            check(gn == ROWS[i].g, $sformatf("R%0d gate-high count row %0d", ROWS[i].tag, i),
                  gn, ROWS[i].g);
        end

        // R10: full 65 kHz period, crossing present from the start
        run_cycle(P65K, 0, P65K, 0, 0, 0, hn, gn);
        check(gn == P65K - 1 - OFF - 1, "R10 gate-high count", gn, P65K - 1 - OFF - 1);
        check((gn + 1) * 100 <= 95 * P65K, "R10 duty bound", (gn + 1) * 100, 95 * P65K);

        // R5 and R9: latch holds without crossing; disable masks at once
        cycle_start = 1'b0;
        ramp_cross  = 1'b0;
        oc_raw      = 1'b0;
        #1;
        check(gate_out == 1'b1, "R5 held on without crossing", int'(gate_out), 1);
        @(negedge clk);
        fault_off = 1'b1;
        #1;
        check(gate_out == 1'b0, "R9 same-cycle disable", int'(gate_out), 0);
        @(negedge clk);
        fault_off = 1'b0;
        #1;
        check(gate_out == 1'b1, "R9 latch kept through disable", int'(gate_out), 1);

        check(overlap == 0, "R2 gate during window", overlap, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        done = 1'b1;
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule